// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Logic Target

This block brings up a programmable logic device over a slave-serial configuration link. After a `start` pulse it pulls the target's active-low program line, waits for the target to report that its configuration memory is clear, and releases the program line. It then waits for the target to say it is ready for data. Next it clocks a stream of configuration bits into the target, one bit for each valid/ready transfer from an upstream source. At the end it waits for the target's completion flag.

Every bit goes out in four equal phases, and the clock and data lines rest high between bits. Each of the three waits on the target has its own timeout, counted in ticks of a prescaled time base. A timeout ends the run with a result code for that wait. The phase length, the tick length and the tick limit are parameters given in clock cycles, so a short configuration can be used in simulation.

Top module: `fpga_cfg_loader`

## Requirements
- R1: When idle, `prog_n`, `cfg_clk` and `cfg_data` are high, `busy` is low and `bit_ready` is low.
- R2: The cycle after `start` is sampled in idle, `prog_n` is low and `busy` is high, while `cfg_clk` and `cfg_data` stay high. `busy` stays high until the status pulse.
- R3: If `init_line` is not seen low within WIN = LIMIT_TICKS*TICK_CYCLES cycles of `prog_n` falling, the run ends with code 1. `status_valid` is high exactly WIN cycles after the fall. `init_line` low first seen in cycle WIN-1 still counts as in time.
- R4: Once `init_line` is seen low, `prog_n` returns high and stays high for the rest of the run. If `init_line` is not seen high within WIN cycles of that release, the run ends with code 2, with status exactly WIN cycles after the release.
- R5: Bits are accepted only after the target is ready, one per cycle in which `bit_valid` and `bit_ready` are both high. Each bit spans four phases of PHASE_CYCLES cycles each: clock low with data high, data equal to the bit, clock high, data high again. Back-to-back bits put rising clock edges exactly 4*PHASE_CYCLES cycles apart.
- R6: Bits appear on `cfg_data` at the rising edges of `cfg_clk` in the order in which they were accepted. The bench packs bytes most significant bit first. The bit accepted with `bit_last` high ends the stream.
- R7: After the last bit's fourth phase, the block waits for `done_line` high and then reports code 0. If `done_line` is not seen high within WIN cycles, it reports code 3, which falls 2*PHASE_CYCLES+WIN cycles after the last rising clock edge.
- R8: `status_valid` is a one-cycle pulse. `busy` is low in that cycle. `status_code` holds its value until the next accepted start.
- R9: A `start` pulse while `busy` is high has no effect: `prog_n` does not fall again and the run completes with its normal result.
- R10: Whenever no bit is in flight, `cfg_clk` and `cfg_data` rest high. Data is high whenever the clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| bit_valid | input | 1 | Upstream bit is present |
| bit_value | input | 1 | Upstream configuration bit |
| bit_last | input | 1 | Marks the final bit of the stream |
| bit_ready | output | 1 | Loader accepts a bit this cycle |
| prog_n | output | 1 | Active-low program line to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | 1 | Serial configuration data to the target |
| init_line | input | 1 | Target init/ready line |
| done_line | input | 1 | Target completion line |
| busy | output | 1 | A run is in progress |
| status_valid | output | 1 | One-cycle pulse at the end of a run |
| status_code | output | 2 | 0 ok, 1 init-low timeout, 2 init-high timeout, 3 done timeout |

## Verification
Every timing result has a fixed distance from a visible event. `prog_n` falls one cycle after the start is sampled. The init-low timeout status arrives WIN cycles after that fall, and the init-high timeout WIN cycles after `prog_n` rises. The done timeout arrives 2*PHASE_CYCLES+WIN cycles after the last rising `cfg_clk`. Rising clock edges of back-to-back bits are exactly 4*PHASE_CYCLES cycles apart. The bench keeps a free-running cycle count and samples every line at the falling clock edge. It stamps each edge it sees with that count and compares differences of stamps against these formulas. Its model target lets each handshake line move a set number of cycles after its trigger, and sweeps that delay across the cycle WIN-1 at which an answer is just in time.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_INITW = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONEW = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    RC_OK      = 2'd0,
    RC_INIT_LO = 2'd1,
    RC_INIT_HI = 2'd2,
    RC_DONE    = 2'd3
  } result_t;

endpackage

// File: rtl/cfgld_rst_sync.sv
module cfgld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sn = sync_q;
endmodule

// File: rtl/cfgld_wait_timer.sv
module cfgld_wait_timer #(
  parameter int TICK_CYCLES = 50000,
  parameter int LIMIT_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int TW = (LIMIT_TICKS > 1) ? $clog2(LIMIT_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST  = PW'(TICK_CYCLES - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(LIMIT_TICKS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] ticks_q, ticks_d;
  logic          tick;

  assign tick    = run && (pre_q == PRE_LAST);
  assign expired = tick && (ticks_q == TICK_LAST);

  always_comb begin
    pre_d   = pre_q;
    ticks_d = ticks_q;
    if (clr) begin
      pre_d   = '0;
      ticks_d = '0;
    end else if (run) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) ticks_d = ticks_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      ticks_q <= '0;
    end else begin
      pre_q   <= pre_d;
      ticks_q <= ticks_d;
    end
  end

  // R3: the tick count never passes the limit, since expiry always restarts the window
  p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_q <= TICK_LAST);
endmodule

// File: rtl/cfgld_bit_phaser.sv
module cfgld_bit_phaser #(
  parameter int PHASE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic bit_in,
  output logic active,
  output logic bit_end,
  output logic cfg_clk,
  output logic cfg_data
);
  localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYCLES - 1);

  logic          act_q, act_d;
  logic [1:0]    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q, clk_d, dat_q, dat_d, bit_q, bit_d;
  logic          ph_end;

  assign ph_end  = act_q && (cnt_q == CNT_LAST);
  assign bit_end = ph_end && (ph_q == 2'd3);

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    clk_d = clk_q;
    dat_d = dat_q;
    bit_d = bit_q;
    if (take) begin
      act_d = 1'b1;
      ph_d  = 2'd0;
      cnt_d = '0;
      clk_d = 1'b0;
      dat_d = 1'b1;
      bit_d = bit_in;
    end else if (act_q) begin
      if (ph_end) begin
        cnt_d = '0;
        ph_d  = ph_q + 2'd1;
        case (ph_q)
          2'd0:    dat_d = bit_q;
          2'd1:    clk_d = 1'b1;
          2'd2:    dat_d = 1'b1;
          default: act_d = 1'b0;
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= 2'd0;
      cnt_q <= '0;
      clk_q <= 1'b1;
      dat_q <= 1'b1;
      bit_q <= 1'b0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      clk_q <= clk_d;
      dat_q <= dat_d;
      bit_q <= bit_d;
    end
  end

  assign active   = act_q;
  assign cfg_clk  = clk_q;
  assign cfg_data = dat_q;

  // R5: a new bit enters only when the previous one is finished
  p_take_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!act_q || bit_end));
  // R5: the first phase has the clock low and the data high
  p_first_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!cfg_clk && cfg_data));
  // R5: data is already settled when the clock rises
  p_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> $stable(dat_q));
  // R10: clock and data rest high with no bit in flight
  p_rest_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (clk_q && dat_q));
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int PHASE_CYCLES = 4,
  parameter int TICK_CYCLES  = 50000,
  parameter int LIMIT_TICKS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bit_valid,
  input  logic       bit_value,
  input  logic       bit_last,
  output logic       bit_ready,
  output logic       prog_n,
  output logic       cfg_clk,
  output logic       cfg_data,
  input  logic       init_line,
  input  logic       done_line,
  output logic       busy,
  output logic       status_valid,
  output logic [1:0] status_code
);
  logic       rst_sn;
  seq_state_t state_q, state_d;
  result_t    code_q, code_d;
  logic       last_q, last_d;
  logic       sv_q, sv_d;
  logic       wait_run, tmr_clr, expired;
  logic       ph_active, ph_bit_end, take;

  cfgld_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign wait_run = (state_q == ST_PROG) || (state_q == ST_INITW) || (state_q == ST_DONEW);
  assign tmr_clr  = (state_d != state_q);

  cfgld_wait_timer #(
    .TICK_CYCLES (TICK_CYCLES),
    .LIMIT_TICKS (LIMIT_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_sn),
    .clr     (tmr_clr),
    .run     (wait_run),
    .expired (expired)
  );

  assign bit_ready = (state_q == ST_SHIFT) && !last_q && (!ph_active || ph_bit_end);
  assign take      = bit_valid && bit_ready;

  cfgld_bit_phaser #(
    .PHASE_CYCLES (PHASE_CYCLES)
  ) u_phaser (
    .clk      (clk),
    .rst_n    (rst_sn),
    .take     (take),
    .bit_in   (bit_value),
    .active   (ph_active),
    .bit_end  (ph_bit_end),
    .cfg_clk  (cfg_clk),
    .cfg_data (cfg_data)
  );

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    last_d  = last_q;
    sv_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PROG;
          code_d  = RC_OK;
          last_d  = 1'b0;
        end
      end
      ST_PROG: begin
        if (!init_line) begin
          state_d = ST_INITW;
        end else if (expired) begin
          state_d = ST_IDLE;
          code_d  = RC_INIT_LO;
          sv_d    = 1'b1;
        end
      end
      ST_INITW: begin
        if (init_line) begin
          state_d = ST_SHIFT;
        end else if (expired) begin
          state_d = ST_IDLE;
          code_d  = RC_INIT_HI;
          sv_d    = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (take) last_d = bit_last;
        if (ph_bit_end && last_q) state_d = ST_DONEW;
      end
      ST_DONEW: begin
        if (done_line) begin
          state_d = ST_IDLE;
          code_d  = RC_OK;
          sv_d    = 1'b1;
        end else if (expired) begin
          state_d = ST_IDLE;
          code_d  = RC_DONE;
          sv_d    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      code_q  <= RC_OK;
      last_q  <= 1'b0;
      sv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      last_q  <= last_d;
      sv_q    <= sv_d;
    end
  end

  assign prog_n       = (state_q != ST_PROG);
  assign busy         = (state_q != ST_IDLE);
  assign status_valid = sv_q;
  assign status_code  = code_q;

  // R1: all target lines high while idle
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_IDLE) |-> (prog_n && cfg_clk && cfg_data));
  // R2: clock and data held high while the program line is low
  p_prog_pins_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !prog_n |-> (cfg_clk && cfg_data));
  // R8: status pulse is one cycle wide and coincides with not busy
  p_status_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    status_valid |=> !status_valid);
  p_status_idle_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    status_valid |-> !busy);
  // R9: once released, the program line is not pulled again within a run
  p_no_reprog_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && prog_n) |=> prog_n);
endmodule

// File: tb/sim_fpga_cfg_loader.sv
module sim_fpga_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int PH  = 3;
  localparam int TK  = 4;
  localparam int LIM = 5;
  localparam int WIN = TK * LIM;

  logic clk, rst_n;
  logic start, bit_valid, bit_value, bit_last, bit_ready;
  logic prog_n, cfg_clk, cfg_data, init_line, done_line;
  logic busy, status_valid;
  logic [1:0] status_code;

  fpga_cfg_loader #(.PHASE_CYCLES(PH), .TICK_CYCLES(TK), .LIMIT_TICKS(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
    .bit_value(bit_value), .bit_last(bit_last), .bit_ready(bit_ready),
    .prog_n(prog_n), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .init_line(init_line), .done_line(done_line), .busy(busy),
    .status_valid(status_valid), .status_code(status_code));

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  // target model and line monitor
  int  lo_dly, hi_dly, dn_dly, nbits;
  logic model_rst;
  int  c1, c2, c3;
  logic prev_clk, prev_prog;
  logic cap [0:63];
  int  cap_n, rise_cyc, last_rise_cyc, min_sp, max_sp;
  int  fall_cnt, fall_cyc, rel_cyc, bad_fall, bad_rest;

  always @(negedge clk) begin
    if (model_rst) begin
      c1 = 0; c2 = 0; c3 = 0;
      init_line = 1'b1; done_line = 1'b0;
      cap_n = 0; rise_cyc = 0; last_rise_cyc = 0; min_sp = 1 << 30; max_sp = 0;
      fall_cnt = 0; fall_cyc = 0; rel_cyc = 0; bad_fall = 0; bad_rest = 0;
      prev_clk = cfg_clk; prev_prog = prog_n;
    end else begin
      if (cfg_clk && !prev_clk) begin
        if (cap_n > 0) begin
          if (cyc - last_rise_cyc < min_sp) min_sp = cyc - last_rise_cyc;
          if (cyc - last_rise_cyc > max_sp) max_sp = cyc - last_rise_cyc;
        end
        if (cap_n < 64) cap[cap_n] = cfg_data;
        cap_n = cap_n + 1;
        last_rise_cyc = cyc;
      end
      if (!cfg_clk && prev_clk && !cfg_data) bad_fall = bad_fall + 1;
      if (!busy && !(cfg_clk && cfg_data)) bad_rest = bad_rest + 1;
      if (!prog_n && prev_prog) begin fall_cnt = fall_cnt + 1; fall_cyc = cyc; end
      if (prog_n && !prev_prog) rel_cyc = cyc;
      prev_clk = cfg_clk; prev_prog = prog_n;
      if (!prog_n) begin
        c1 = c1 + 1;
        if (lo_dly >= 0 && c1 > lo_dly) init_line = 1'b0;
      end else if (!init_line) begin
        c2 = c2 + 1;
        if (hi_dly >= 0 && c2 > hi_dly) init_line = 1'b1;
      end
      if (nbits > 0 && cap_n == nbits) begin
        c3 = c3 + 1;
        if (dn_dly >= 0 && c3 > dn_dly) done_line = 1'b1;
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic sbits [0:63];

  task automatic load_bytes(input logic [31:0] word, input int nbytes);
    for (int b = 0; b < nbytes; b++)
      for (int i = 0; i < 8; i++)
        sbits[b*8 + i] = word[(nbytes-1-b)*8 + 7 - i];  // MSB first (R6)
  endtask

  task automatic run_case(input int lo, input int hi, input int dn, input int nb,
                          input int gap, input int restart_k, input int exp_code);
    int sent, gapcnt, k, st_cyc, bad_busy;
    logic xfer;
    lo_dly = lo; hi_dly = hi; dn_dly = dn; nbits = nb;
    model_rst = 1'b1;
    step();
    model_rst = 1'b0;
    start = 1'b1;
    step();
    start = 1'b0;
    chk(prog_n == 1'b0 && busy == 1'b1 && cfg_clk && cfg_data, "R2 start",
        {prog_n, busy, cfg_clk, cfg_data}, 4'b0111);
    sent = 0; gapcnt = 0; k = 0; st_cyc = 0; bad_busy = 0;
    bit_valid = 1'b0;
    while (k < 3000) begin
      if (!bit_valid && sent < nb) begin
        if (gapcnt > 0) gapcnt = gapcnt - 1;
        else begin
          bit_valid = 1'b1; bit_value = sbits[sent]; bit_last = (sent == nb - 1);
        end
      end
      start = (k == restart_k);
      xfer = bit_valid && bit_ready;
      step();
      k = k + 1;
      if (xfer) begin
        sent = sent + 1;
        bit_valid = 1'b0;
        gapcnt = gap;
        if (gap == 0 && sent < nb) begin
          bit_valid = 1'b1; bit_value = sbits[sent]; bit_last = (sent == nb - 1);
        end
      end
      if (status_valid) begin st_cyc = cyc; break; end
      if (!busy) bad_busy = bad_busy + 1;
    end
    start = 1'b0;
    bit_valid = 1'b0;
    chk(k < 3000, "R8 status arrives", k, 3000);
    chk(bad_busy == 0, "R2 busy until status", bad_busy, 0);
    chk(status_code == exp_code[1:0], "R3 R4 R7 result code", status_code, exp_code);
    chk(!busy, "R8 not busy at status", busy, 0);
    chk(fall_cnt == 1, "R9 single program pulse", fall_cnt, 1);
    if (exp_code == 1)
      chk(st_cyc - fall_cyc == WIN, "R3 init-low timeout time", st_cyc - fall_cyc, WIN);
    if (exp_code == 2)
      chk(st_cyc - rel_cyc == WIN, "R4 init-high timeout time", st_cyc - rel_cyc, WIN);
    if (exp_code == 3)
      chk(st_cyc - last_rise_cyc == 2*PH + WIN, "R7 done timeout time",
          st_cyc - last_rise_cyc, 2*PH + WIN);
    if (exp_code == 1 || exp_code == 2) begin
      chk(cap_n == 0 && sent == 0, "R5 no bits before ready", cap_n + sent, 0);
    end else begin
      chk(sent == nb && cap_n == nb, "R6 bit count", cap_n, nb);
      for (int i = 0; i < nb; i++)
        chk(cap[i] == sbits[i], "R6 bit order", cap[i], sbits[i]);
      if (gap == 0 && nb > 1) begin
        chk(min_sp == 4*PH && max_sp == 4*PH, "R5 bit period", max_sp, 4*PH);
      end else if (nb > 1) begin
        chk(min_sp >= 4*PH, "R5 bit period with gaps", min_sp, 4*PH);
      end
    end
    chk(bad_fall == 0, "R10 data high at clock fall", bad_fall, 0);
    step();
    chk(!status_valid, "R8 one-cycle pulse", status_valid, 0);
    step(); step();
    chk(status_code == exp_code[1:0], "R8 code held", status_code, exp_code);
    chk(prog_n && cfg_clk && cfg_data && !busy && !bit_ready, "R1 idle lines",
        {prog_n, cfg_clk, cfg_data, busy, bit_ready}, 5'b11100);
    chk(bad_rest == 0, "R10 rest high when idle", bad_rest, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; bit_valid = 1'b0; bit_value = 1'b0; bit_last = 1'b0;
    model_rst = 1'b1; lo_dly = 0; hi_dly = 0; dn_dly = 0; nbits = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk(prog_n && cfg_clk && cfg_data && !busy && !bit_ready && !status_valid,
        "R1 reset state", {prog_n, cfg_clk, cfg_data, busy, bit_ready}, 5'b11100);

    load_bytes(32'h0000_00A5, 1); run_case(0, 0, 0, 8, 0, -1, 0);
    load_bytes(32'h0000_00FF, 2); run_case(10, 14, 14, 16, 0, -1, 0);
    load_bytes(32'h3C81_5A00, 4); run_case(3, 5, 2, 32, 0, -1, 0);
    run_case(-1, 0, 0, 8, 0, -1, 1);
    run_case(25, 0, 0, 8, 0, -1, 1);
    run_case(2, -1, 0, 8, 0, -1, 2);
    run_case(2, 26, 0, 8, 0, -1, 2);
    load_bytes(32'h0000_003C, 1); run_case(2, 2, -1, 8, 0, -1, 3);
    run_case(2, 2, 30, 8, 0, -1, 3);
    // R9: start pulsed mid-run, with gaps between bits
    load_bytes(32'h0000_815A, 2); run_case(1, 1, 1, 16, 3, 30, 0);
    // single bit stream
    sbits[0] = 1'b0; run_case(0, 0, 0, 1, 0, -1, 0);
    // R3/R4/R7 boundary sweeps around the last in-time cycle
    load_bytes(32'h0000_0096, 1);
    for (int d = WIN - 4; d <= WIN + 2; d++) run_case(d, 0, 0, 8, 0, -1, (d <= WIN - 1) ? 0 : 1);
    for (int d = WIN - 3; d <= WIN + 2; d++) run_case(0, d, 0, 8, 0, -1, (d <= WIN - 1) ? 0 : 2);
    for (int d = 2*PH + WIN - 3; d <= 2*PH + WIN + 2; d++)
      run_case(0, 0, d, 8, 0, -1, (d <= 2*PH + WIN - 1) ? 0 : 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule